// File: doc/BRIEF.md
# Prescaled Oversampling Data-Ready Generator

This block derives the timing strobes of a delta-sigma converter front end from one master clock. A two-bit prescale selection divides the master clock into an analog master clock. That clock is divided by four to give the modulator clock. An oversampling counter then counts modulator cycles and raises a data-ready strobe once per conversion period. All derived clocks leave the block as single-cycle enables, so the rest of the chip stays in the master clock domain.

Data-ready is active low for one master-clock cycle. The period is 4 × OSR × prescale master cycles. For example, a 4 MHz master clock with prescale 1 and OSR 256 gives about 3.9 kHz. After reset, and after any change to the prescale or OSR selection, the counters restart. The first two data-ready events are then held back so that the decimation filter can settle. A status flag stays set until the first visible strobe, and a sample index counts the strobes issued since the last restart. Several instances that share the master clock, the reset and the configuration produce aligned strobes, because the timing depends only on the cycles counted since the restart.

Top module: `drdy_gen`

## Requirements
- R1: `amclk_tick_o` is high in the master cycles where (n+1) is a multiple of 2^pre_sel_i. Here n is the number of master-clock edges since the last restart, and the codes 0,1,2,3 select division by 1,2,4,8.
- R2: `dmclk_tick_o` is high in the cycles where (n+1) is a multiple of 4·2^pre_sel_i. It is high only together with `amclk_tick_o`.
- R3: After settling, `drdy_no` is low in the cycles where (n+1) is a multiple of P = 4·OSR·2^pre_sel_i. OSR is 2^(osr_sel_i+5), so code 0 gives 32 and code 7 gives 4096.
- R4: After a restart, the first low cycle of `drdy_no` is n = 3P−1, which is two periods later than the steady-state grid would place it.
- R5: Each data-ready pulse is low for exactly one master cycle.
- R6: A change of either selection input is taken at the next clock edge. At that edge all counters return to zero, the sample index clears and the settling delay is applied again. Rewriting an unchanged value has no effect.
- R7: `settling_o` is high from reset or restart up to and including the first low cycle of `drdy_no`, and low afterwards.
- R8: `sample_idx_o` increments by one at the edge that ends each data-ready pulse and wraps at its width.
- R9: During and right after reset, `drdy_no` is high, `settling_o` is high and `sample_idx_o` is 0. The default selection is prescale 1 and OSR 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pre_sel_i | input | 2 | Prescale code, division 2^code |
| osr_sel_i | input | 3 | Oversampling code, OSR 2^(code+5) |
| amclk_tick_o | output | 1 | Analog master clock enable |
| dmclk_tick_o | output | 1 | Modulator clock enable |
| drdy_no | output | 1 | Data-ready strobe, active low |
| settling_o | output | 1 | Filter settling in progress |
| sample_idx_o | output | 8 | Strobes issued since restart |

## Verification
A divider that is off by one shifts every tick of `amclk_tick_o` or `dmclk_tick_o` within a few cycles. In the OSR counter, the same error moves the first strobe by a multiple of the modulator period. A settle counter that is wrong shows up as a first strobe one period early or late. It also shows up as `settling_o` clearing in the wrong cycle, and this is visible within 3P cycles of a restart. A restart that is not taken leaves the pulse grid and `sample_idx_o` running on the old phase, which differs from the expected values at the first cycle after the change.

// File: rtl/drdy_gen_pkg.sv
package drdy_gen_pkg;
  localparam int PRE_W        = 2;
  localparam int OSR_W        = 3;
  localparam int OSR_LOG2_MIN = 5;
  localparam int PRE_CNT_W    = (1 << PRE_W) - 1;
  localparam int OSR_CNT_W    = OSR_LOG2_MIN + (1 << OSR_W) - 1;
  localparam int MOD_CNT_W    = 2;
  localparam int SETTLE_PER   = 2;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic [OSR_W-1:0] osr;
  } cfg_t;

  function automatic logic [PRE_CNT_W-1:0] pre_limit(input logic [PRE_W-1:0] s);
    return PRE_CNT_W'((1 << s) - 1);
  endfunction

  function automatic logic [OSR_CNT_W-1:0] osr_limit(input logic [OSR_W-1:0] s);
    return OSR_CNT_W'((1 << (int'(s) + OSR_LOG2_MIN)) - 1);
  endfunction
endpackage

// File: rtl/tick_div.sv
module tick_div #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else if (en_i)    cnt_q <= cnt_q + 1'b1;
  end

  // covers R1 (prescaler), R2 (modulator) and R3 (oversampling) instances
  assert_cnt_le_limit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= limit_i);
endmodule

// File: rtl/settle_gate.sv
module settle_gate #(
  parameter int SETTLE = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic term_i,
  output logic fire_o,
  output logic settling_o
);
  localparam int SW = $clog2(SETTLE + 2);
  localparam logic [SW-1:0] DONE = SW'(SETTLE + 1);

  logic [SW-1:0] seen_q;

  assign fire_o     = term_i && (seen_q >= SW'(SETTLE));
  assign settling_o = (seen_q != DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     seen_q <= '0;
    else if (clr_i)                  seen_q <= '0;
    else if (term_i && seen_q != DONE) seen_q <= seen_q + 1'b1;
  end

  assert_settle_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && !clr_i) |=> !settling_o);
  assert_no_fire_early_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_i && seen_q < SW'(SETTLE)) |-> !fire_o);
endmodule

// File: rtl/drdy_gen.sv
module drdy_gen
  import drdy_gen_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PRE_W-1:0] pre_sel_i,
  input  logic [OSR_W-1:0] osr_sel_i,
  output logic             amclk_tick_o,
  output logic             dmclk_tick_o,
  output logic             drdy_no,
  output logic             settling_o,
  output logic [IDX_W-1:0] sample_idx_o
);
  cfg_t cfg_q, cfg_d;
  logic restart, osr_term, fire;
  logic [IDX_W-1:0] idx_q;

  assign cfg_d   = '{pre: pre_sel_i, osr: osr_sel_i};
  assign restart = (cfg_d != cfg_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cfg_q <= '0;
    else if (restart) cfg_q <= cfg_d;
  end

  tick_div #(.CNT_W(PRE_CNT_W)) u_pre (
    .clk_i, .rst_ni, .clr_i(restart), .en_i(1'b1),
    .limit_i(pre_limit(cfg_q.pre)), .tick_o(amclk_tick_o));

  tick_div #(.CNT_W(MOD_CNT_W)) u_mod (
    .clk_i, .rst_ni, .clr_i(restart), .en_i(amclk_tick_o),
    .limit_i(MOD_CNT_W'(3)), .tick_o(dmclk_tick_o));

  tick_div #(.CNT_W(OSR_CNT_W)) u_osr (
    .clk_i, .rst_ni, .clr_i(restart), .en_i(dmclk_tick_o),
    .limit_i(osr_limit(cfg_q.osr)), .tick_o(osr_term));

  settle_gate #(.SETTLE(SETTLE_PER)) u_settle (
    .clk_i, .rst_ni, .clr_i(restart), .term_i(osr_term),
    .fire_o(fire), .settling_o(settling_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= '0;
    else if (restart) idx_q <= '0;
    else if (fire)    idx_q <= idx_q + 1'b1;
  end

  assign drdy_no      = ~fire;
  assign sample_idx_o = idx_q;

  assert_drdy_one_cycle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drdy_no |=> drdy_no);
  assert_restart_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> (settling_o && sample_idx_o == '0 && drdy_no));
  assert_dm_with_am_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmclk_tick_o |-> amclk_tick_o);
  assert_drdy_on_dm_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drdy_no |-> dmclk_tick_o);
  assert_idx_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!drdy_no && !restart) |=> sample_idx_o == $past(sample_idx_o) + 1'b1);
endmodule

// File: tb/tb_drdy_gen.sv
module tb_drdy_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] pre_sel_i = '0;
  logic [2:0] osr_sel_i = '0;
  logic       amclk_tick_o, dmclk_tick_o, drdy_no, settling_o;
  logic [7:0] sample_idx_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int cur_pre = 0;
  int cur_osr = 0;

  always #2ns clk_i = ~clk_i;

  drdy_gen dut (.*);

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 195000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected<=195000", cycles);
      summary();
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int period(input int p, input int o);
    return 4 * (1 << (o + 5)) * (1 << p);
  endfunction

  // Check all outputs for n = j0 .. n_end; caller sits at the negedge of n = j0
  task automatic run_window(input int p, input int o, input int j0, input int n_end);
    int div = 1 << p;
    int per = period(p, o);
    for (int j = j0; j <= n_end; j++) begin
      if (j != j0) begin
        @(posedge clk_i);
        @(negedge clk_i);
      end
      chk("R1 amclk", amclk_tick_o, ((j + 1) % div) == 0);
      chk("R2 dmclk", dmclk_tick_o, ((j + 1) % (4 * div)) == 0);
      chk((j + 1 < 3 * per) ? "R4 drdy" : "R3 R5 drdy", drdy_no,
          !(((j + 1) % per) == 0 && (j + 1) >= 3 * per));
      chk("R7 settling", settling_o, j <= 3 * per - 1);
      chk("R8 idx", sample_idx_o, (j >= 3 * per) ? (((j - 3 * per) / per + 1) % 256) : 0);
    end
  endtask

  // Apply a new configuration at a negedge; restart takes effect at the next edge
  task automatic apply(input int p, input int o);
    pre_sel_i = 2'(p);
    osr_sel_i = 3'(o);
    cur_pre = p;
    cur_osr = o;
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R6 restart idx", sample_idx_o, 0);
    chk("R6 restart settling", settling_o, 1);
  endtask

  initial begin
    int p, o;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    chk("R9 reset drdy", drdy_no, 1);
    chk("R9 reset settling", settling_o, 1);
    chk("R9 reset idx", sample_idx_o, 0);
    rst_ni = 1'b1;
    // default config straight out of reset
    run_window(0, 0, 0, 5 * period(0, 0));

    // R6: change mid-period, grid restarts from the change
    apply(1, 0);
    run_window(1, 0, 0, 300);
    apply(0, 1);
    run_window(0, 1, 0, 5 * period(0, 1));

    // R6: rewriting identical values must not restart; continue the grid
    @(negedge clk_i);
    pre_sel_i = 2'(cur_pre);
    osr_sel_i = 3'(cur_osr);
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R6 no restart idx", sample_idx_o, ((5 * period(0, 1) + 2 - 3 * period(0, 1)) / period(0, 1) + 1));

    // largest prescale with smallest OSR
    apply(3, 0);
    run_window(3, 0, 0, 5 * period(3, 0));

    // largest OSR: first pulse only (R4)
    apply(0, 7);
    run_window(0, 7, 0, 3 * period(0, 7) + 1);

    // random configurations, always different from the current one
    for (int k = 0; k < 6; k++) begin
      p = int'($urandom_range(3, 0));
      o = int'($urandom_range(1, 0));
      if (p == cur_pre && o == cur_osr) o = 1 - o;
      apply(p, o);
      run_window(p, o, 0, 4 * period(p, o) + 3);
    end
    summary();
  end
endmodule